// File: doc/BRIEF.md
# Frequency Table Text Report Streamer

This block turns a stored table of binary frequencies into a readable text report. A single-cycle request starts one pass. The block fetches the power-on default entry and then every channel entry in turn, and renders each value as zero-padded decimal digits. It sends the resulting characters one byte at a time to a serial transmitter that sits downstream.

Storage is external. The block drives a read strobe and an address, and expects the entry on `rd_data` exactly one cycle later. Table address 0 holds the default value, and address k+1 holds channel k. Values must not exceed 999,999,999 Hz.

The output side is a byte stream with valid/ready handshaking. A byte moves in a cycle where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, the block keeps `tx_valid` high and keeps `tx_data` unchanged. Nothing is dropped and nothing is repeated. The downstream side may hold `tx_ready` low for as long as it needs. `busy` is a plain status output that covers the whole pass.

Top module: `tblrep_top`

## Requirements
- R1: Out of reset, `busy`, `tx_valid` and `rd_en` are all low.
- R2: A request seen while idle raises `busy` in the next cycle. The block then reads table addresses 0 through NUM_CH, in ascending order and once each. Address 0 is the default, and address k+1 is channel k.
- R3: The first line of the report holds nine ASCII decimal digits of the default value, most significant first and zero-padded on the left, followed by CR (0x0D) and LF (0x0A). Digit d is sent as 0x30+d.
- R4: Each channel k (0 to NUM_CH-1) gets one line, in ascending order. The line holds the index as three zero-padded decimal digits, then a space (0x20), then the nine-digit value, then CR and LF.
- R5: After the last channel line, a single '*' (0x2A) is sent with no line ending. The report is therefore exactly 11 + 15*NUM_CH + 1 bytes (1812 for 120 channels).
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged. The stream advances only on a valid-and-ready cycle.
- R7: A request that arrives while a report is in progress is ignored. The running report is unchanged and no second report follows.
- R8: `busy` stays high from the cycle after the accepted request until the '*' byte has been handed off. It is low in the following cycle.
- R9: The block samples the table word exactly one cycle after the cycle in which `rd_en` is high. Data on `rd_data` at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump_req | input | 1 | Starts a report when idle |
| busy | output | 1 | High for the whole report |
| rd_en | output | 1 | Table read strobe |
| rd_addr | output | ADDR_W | Table address (0 = default, k+1 = channel k) |
| rd_data | input | FREQ_W | Table word, valid one cycle after `rd_en` |
| tx_data | output | 8 | Report byte |
| tx_valid | output | 1 | `tx_data` holds a byte |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench places the extreme values 0, 1, 100,000,000 and 999,999,999 at the first and last table positions. A converter that loses a bit or mis-pads would print a wrong or short digit string there, and an off-by-one entry counter would skip or repeat a channel. The table model drives an all-ones word on `rd_data` in every cycle except the cycle after a read. A design that samples in the wrong cycle would therefore print 073741823-style garbage. The bench throttles `tx_ready` at random and pulses the request in mid-report. This exposes a design that drops or changes a byte under back-pressure, or one that restarts or chains a second report.

// File: rtl/tblrep_pkg.sv
package tblrep_pkg;

  localparam int FREQ_DIGITS = 9;
  localparam int IDX_DIGITS  = 3;

  // Unified byte positions within an indexed line; the default line
  // is the same layout starting at POS_FREQ0.
  localparam int POS_SPACE = IDX_DIGITS;
  localparam int POS_FREQ0 = IDX_DIGITS + 1;
  localparam int POS_CR    = POS_FREQ0 + FREQ_DIGITS;
  localparam int POS_LF    = POS_CR + 1;

  localparam logic [7:0] ASC_ZERO  = 8'h30;
  localparam logic [7:0] ASC_SPACE = 8'h20;
  localparam logic [7:0] ASC_CR    = 8'h0D;
  localparam logic [7:0] ASC_LF    = 8'h0A;
  localparam logic [7:0] ASC_STAR  = 8'h2A;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_CONV,
    ST_EMIT,
    ST_PROMPT
  } seq_state_t;

endpackage

// File: rtl/tblrep_bcd_conv.sv
module tblrep_bcd_conv #(
  parameter int BIN_W  = 30,
  parameter int DIGITS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BIN_W-1:0]      bin_in,
  output logic                  done,
  output logic [4*DIGITS-1:0]   bcd_out
);

  localparam int CNT_W = $clog2(BIN_W + 1);

  logic [BIN_W-1:0]    shreg;
  logic [4*DIGITS-1:0] bcd;
  logic [4*DIGITS-1:0] adj;
  logic [CNT_W-1:0]    cnt;
  logic                running;

  // add-3 correction on every digit before each shift
  for (genvar g = 0; g < DIGITS; g++) begin : g_adj
    always_comb begin
      if (bcd[4*g +: 4] >= 4'd5) adj[4*g +: 4] = bcd[4*g +: 4] + 4'd3;
      else                       adj[4*g +: 4] = bcd[4*g +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bcd     <= '0;
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      shreg   <= bin_in;
      bcd     <= '0;
      cnt     <= '0;
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running) begin
      {bcd, shreg} <= {adj, shreg} << 1;
      cnt          <= cnt + 1'b1;
      if (cnt == CNT_W'(BIN_W - 1)) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  assign bcd_out = bcd;

  // R3: every finished digit is a legal decimal digit
  for (genvar g = 0; g < DIGITS; g++) begin : g_chk
    a_r3_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bcd[4*g +: 4] <= 4'd9));
  end

  // R9: a start launches a conversion that is not yet finished
  a_r9_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && !done));

endmodule

// File: rtl/tblrep_idx_ctr.sv
module tblrep_idx_ctr #(
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  output logic [4*N-1:0] digits
);

  logic [N-1:0] carry;

  assign carry[0] = inc;

  for (genvar g = 0; g < N; g++) begin : g_dig
    logic nine;
    assign nine = (digits[4*g +: 4] == 4'd9);
    if (g < N - 1) begin : g_c
      assign carry[g+1] = carry[g] & nine;
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clr)  digits[4*g +: 4] <= 4'd0;
      else if (carry[g])  digits[4*g +: 4] <= nine ? 4'd0 : digits[4*g +: 4] + 4'd1;
    end
    // R4: the index counter keeps decimal digits
    a_r4_idx_decimal: assert property (@(posedge clk) disable iff (!rst_n)
      digits[4*g +: 4] <= 4'd9);
  end

endmodule

// File: rtl/tblrep_byte_mux.sv
module tblrep_byte_mux
  import tblrep_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic [POS_W-1:0]          pos,
  input  logic                      prompt,
  input  logic [4*IDX_DIGITS-1:0]   idx_bcd,
  input  logic [4*FREQ_DIGITS-1:0]  freq_bcd,
  output logic [7:0]                byte_out
);

  always_comb begin
    int p;
    int k;
    p = int'(pos);
    k = 0;
    if (prompt) begin
      byte_out = ASC_STAR;
    end else if (p < POS_SPACE) begin
      k = IDX_DIGITS - 1 - p;
      byte_out = ASC_ZERO | {4'h0, idx_bcd[4*k +: 4]};
    end else if (p == POS_SPACE) begin
      byte_out = ASC_SPACE;
    end else if (p < POS_CR) begin
      k = FREQ_DIGITS - 1 - (p - POS_FREQ0);
      byte_out = ASC_ZERO | {4'h0, freq_bcd[4*k +: 4]};
    end else if (p == POS_CR) begin
      byte_out = ASC_CR;
    end else begin
      byte_out = ASC_LF;
    end
  end

endmodule

// File: rtl/tblrep_seq.sv
module tblrep_seq
  import tblrep_pkg::*;
#(
  parameter int NUM_CH = 120,
  parameter int ADDR_W = 7,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              tx_ready,
  input  logic              conv_done,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              conv_start,
  output logic              idx_clr,
  output logic              idx_inc,
  output logic              tx_valid,
  output logic              prompt,
  output logic [POS_W-1:0]  pos
);

  localparam logic [ADDR_W-1:0] LAST_ENTRY = ADDR_W'(NUM_CH);
  localparam logic [POS_W-1:0]  LF_POS     = POS_W'(POS_LF);
  localparam logic [POS_W-1:0]  DEF_START  = POS_W'(POS_FREQ0);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] entry_q;
  logic [POS_W-1:0]  pos_q;
  logic              line_end;

  always_comb begin
    busy       = (state_q != ST_IDLE);
    rd_en      = (state_q == ST_FETCH);
    rd_addr    = entry_q;
    conv_start = (state_q == ST_LATCH);
    tx_valid   = (state_q == ST_EMIT) || (state_q == ST_PROMPT);
    prompt     = (state_q == ST_PROMPT);
    pos        = pos_q;
    line_end   = (state_q == ST_EMIT) && tx_ready && (pos_q == LF_POS);
    idx_clr    = (state_q == ST_IDLE) && req;
    idx_inc    = line_end && (entry_q != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      entry_q <= '0;
      pos_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req) begin
            state_q <= ST_FETCH;
            entry_q <= '0;
          end
        end
        ST_FETCH: state_q <= ST_LATCH;
        ST_LATCH: state_q <= ST_CONV;
        ST_CONV: begin
          if (conv_done) begin
            state_q <= ST_EMIT;
            pos_q   <= (entry_q == '0) ? DEF_START : '0;
          end
        end
        ST_EMIT: begin
          if (tx_ready) begin
            if (pos_q == LF_POS) begin
              if (entry_q == LAST_ENTRY) begin
                state_q <= ST_PROMPT;
              end else begin
                entry_q <= entry_q + 1'b1;
                state_q <= ST_FETCH;
              end
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
        end
        ST_PROMPT: begin
          if (tx_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: an offered byte is not withdrawn
  a_r6_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid);

  // R9: each read strobe lasts one cycle and is followed by a capture
  a_r9_capture_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (conv_start && !rd_en));

  // R2: addresses stay inside the table
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= LAST_ENTRY));

  // R8: nothing moves while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_valid && !rd_en));

endmodule

// File: rtl/tblrep_top.sv
module tblrep_top
  import tblrep_pkg::*;
#(
  parameter int NUM_CH = 120,
  parameter int FREQ_W = 30,
  parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dump_req,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [FREQ_W-1:0] rd_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);

  localparam int POS_W = $clog2(POS_LF + 1);

  logic                     conv_start;
  logic                     conv_done;
  logic [4*FREQ_DIGITS-1:0] freq_bcd;
  logic [4*IDX_DIGITS-1:0]  idx_bcd;
  logic                     idx_clr;
  logic                     idx_inc;
  logic                     prompt;
  logic [POS_W-1:0]         pos;

  tblrep_seq #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .POS_W  (POS_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (dump_req),
    .tx_ready   (tx_ready),
    .conv_done  (conv_done),
    .busy       (busy),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .conv_start (conv_start),
    .idx_clr    (idx_clr),
    .idx_inc    (idx_inc),
    .tx_valid   (tx_valid),
    .prompt     (prompt),
    .pos        (pos)
  );

  tblrep_bcd_conv #(
    .BIN_W  (FREQ_W),
    .DIGITS (FREQ_DIGITS)
  ) u_conv (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (conv_start),
    .bin_in  (rd_data),
    .done    (conv_done),
    .bcd_out (freq_bcd)
  );

  tblrep_idx_ctr #(
    .N (IDX_DIGITS)
  ) u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (idx_clr),
    .inc    (idx_inc),
    .digits (idx_bcd)
  );

  tblrep_byte_mux #(
    .POS_W (POS_W)
  ) u_mux (
    .pos      (pos),
    .prompt   (prompt),
    .idx_bcd  (idx_bcd),
    .freq_bcd (freq_bcd),
    .byte_out (tx_data)
  );

  // R6: a stalled byte keeps its value
  a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  // R8: handing off the prompt ends the busy window
  a_r8_prompt_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_data == ASC_STAR) |=> !busy);

  // R7: a request during a report does not end or restart it
  a_r7_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dump_req && !tx_valid) |=> busy);

endmodule

// File: tb/tb_tblrep_top.sv
`timescale 1ns/1ps
module tb_tblrep_top;

  localparam int NUM_CH = 120;
  localparam int FREQ_W = 30;
  localparam int ADDR_W = $clog2(NUM_CH + 1);
  localparam int TOTAL  = 11 + 15*NUM_CH + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dump_req = 1'b0;
  logic              busy;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [FREQ_W-1:0] rd_data = '1;
  logic [7:0]        tx_data;
  logic              tx_valid;
  logic              tx_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [FREQ_W-1:0] mem [0:NUM_CH];
  logic [7:0]        exp_b [0:TOTAL-1];
  logic [7:0]        cap   [0:2047];
  int                cap_n = 0;
  int                rdy_mode = 0;
  logic              prev_stall = 1'b0;
  logic [7:0]        prev_data = 8'h0;
  logic              star_pending = 1'b0;

  always #4 clk = ~clk;

  tblrep_top #(.NUM_CH(NUM_CH), .FREQ_W(FREQ_W)) dut (
    .clk(clk), .rst_n(rst_n), .dump_req(dump_req), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  // table model: word valid only in the cycle after a read (R9)
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    else       rd_data <= '1;
  end

  task automatic check(input string req, input logic ok, input longint got, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, expv);
    end
  endtask

  // capture, back-pressure and end-of-busy checks, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (star_pending) begin
        check("R8 busy low after prompt", busy == 1'b0, busy, 0);
        star_pending = 1'b0;
      end
      if (prev_stall)
        check("R6 held byte", tx_valid && tx_data == prev_data, tx_data, prev_data);
      tx_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        if (cap_n < 2048) cap[cap_n] = tx_data;
        cap_n++;
        if (tx_data == 8'h2A) begin
          check("R8 busy during prompt", busy == 1'b1, busy, 1);
          star_pending = 1'b1;
        end
      end
    end
  end

  function automatic int pow10(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

  task automatic build_expected();
    int n = 0;
    for (int i = 8; i >= 0; i--) exp_b[n++] = 8'h30 + 8'((int'(mem[0]) / pow10(i)) % 10);
    exp_b[n++] = 8'h0D;
    exp_b[n++] = 8'h0A;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int i = 2; i >= 0; i--) exp_b[n++] = 8'h30 + 8'((c / pow10(i)) % 10);
      exp_b[n++] = 8'h20;
      for (int i = 8; i >= 0; i--) exp_b[n++] = 8'h30 + 8'((int'(mem[c+1]) / pow10(i)) % 10);
      exp_b[n++] = 8'h0D;
      exp_b[n++] = 8'h0A;
    end
    exp_b[n] = 8'h2A;
  endtask

  task automatic compare_report();
    int bad;
    check("R5 byte count", cap_n == TOTAL, cap_n, TOTAL);
    bad = -1;
    for (int i = 0; i < 11; i++) if (bad < 0 && cap[i] != exp_b[i]) bad = i;
    check("R3 default line", bad < 0, (bad < 0) ? 0 : cap[bad], (bad < 0) ? 0 : exp_b[bad]);
    for (int c = 0; c < NUM_CH; c++) begin
      bad = -1;
      for (int i = 11 + 15*c; i < 26 + 15*c; i++) if (bad < 0 && cap[i] != exp_b[i]) bad = i;
      check($sformatf("R4 line for channel %0d", c), bad < 0,
            (bad < 0) ? 0 : cap[bad], (bad < 0) ? 0 : exp_b[bad]);
    end
    check("R5 closing prompt", cap[TOTAL-1] == 8'h2A, cap[TOTAL-1], 8'h2A);
  endtask

  task automatic run_report(input int mode, input bit poke);
    rdy_mode = mode;
    cap_n = 0;
    build_expected();
    @(negedge clk);
    check("R2 idle before request", busy == 1'b0, busy, 0);
    dump_req = 1'b1;
    @(negedge clk);
    dump_req = 1'b0;
    check("R2 busy after request", busy == 1'b1, busy, 1);
    if (poke) begin
      repeat (700) @(negedge clk);
      dump_req = 1'b1;       // R7: request during a report
      @(negedge clk);
      dump_req = 1'b0;
    end
    while (busy) @(negedge clk);
    compare_report();
    repeat (300) @(negedge clk);
    check("R7 no second report", cap_n == TOTAL && busy == 1'b0, cap_n, TOTAL);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i <= NUM_CH; i++) mem[i] = FREQ_W'($urandom % 1000000000);
    mem[0] = 0;
    mem[1] = 999999999;
    mem[2] = 1;
    mem[NUM_CH] = 100000000;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", busy == 1'b0, busy, 0);
    check("R1 tx_valid at reset", tx_valid == 1'b0, tx_valid, 0);
    check("R1 rd_en at reset", rd_en == 1'b0, rd_en, 0);
    rst_n = 1'b1;
    // R3 R4 R5 R7 R9: full-rate report with a mid-report request
    run_report(0, 1'b1);
    // R6: second table under random back-pressure
    for (int i = 0; i <= NUM_CH; i++)
      mem[i] = FREQ_W'((i % 4 == 0) ? ($urandom % 1000) : ($urandom % 1000000000));
    mem[0] = 999999999;
    mem[NUM_CH] = 0;
    run_report(1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=busy expected=idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule